// File: doc/BRIEF.md
# High-Speed Serial Receive Path

This block is the receive half of a fast serial port. It takes an asynchronous line carrying fixed 8N1 frames (eight data bits, no parity, one stop bit) and samples it at fourteen ticks per bit cell. The sample tick comes from the block clock divided by a programmable 8-bit rate value. Each received character is written into a 64-entry queue together with a framing-error flag and a break flag.

Software or a bus adapter reads the queue through one 32-bit data word. A single-cycle read strobe removes the head entry. The current fill is visible on a level output.

Two receive requests serve an interrupt controller. The fill trigger is raised while the fill is at or above a coded threshold. The idle timeout is raised when unread data has been sitting in the queue, with no line activity, for a coded number of character times.

Top module: `hsrx_receiver`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant bit first, and a stop bit. The byte appears in bits 7:0 of `rd_word_o`, and bits 31:11 are always zero.
- R2: The sample tick period is `rate_i`+1 clock cycles, and one bit cell lasts 14 sample ticks, so a bit lasts 14*(`rate_i`+1) clock cycles.
- R3: A falling edge is accepted as a start bit only if the line is still low at the middle of the bit cell. A low pulse shorter than half a bit produces no entry.
- R4: A frame whose stop bit is sampled low and whose data is non-zero is stored with bit 9 (framing error) set and bit 10 clear.
- R5: A line held low for a whole frame, stop bit included, stores exactly one entry with data 0, bit 10 (break) set and bit 9 clear. No further entry is stored until the line has returned high.
- R6: With the queue empty, `rd_word_o` reads 0x100 (bit 8 = empty), and a read strobe has no effect on the fill.
- R7: The queue holds 64 entries, returns them in arrival order, and `rx_level_o` gives the number of stored entries.
- R8: A character that completes while 64 entries are stored is dropped. `overrun_o` pulses high for exactly one cycle and the stored entries are unchanged.
- R9: `trig_sel_i` codes 0,1,2,3,4,5 select thresholds of 1,4,8,16,32,48 entries, and codes 6 and 7 select 48. `trig_req_o` is high while the fill is at or above the threshold.
- R10: `tmo_sel_i` code 0 disables the timeout, and codes 1,2,3 select 4, 8 and 16 character times, where a character time is 140 sample ticks. `tmo_req_o` rises once the queue has been non-empty, with no push, no read and no frame in progress, for that long. A read clears it.
- R11: After reset the queue is empty, `rd_word_o` is 0x100, and `trig_req_o`, `tmo_req_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high, asynchronous |
| rate_i | input | 8 | Sample tick divider minus one |
| trig_sel_i | input | 3 | Fill trigger threshold code |
| tmo_sel_i | input | 2 | Idle timeout length code |
| rd_i | input | 1 | Read strobe, pops the head entry |
| rd_word_o | output | 32 | Head entry: data 7:0, empty 8, framing error 9, break 10 |
| rx_level_o | output | 8 | Number of stored entries |
| trig_req_o | output | 1 | Fill trigger request |
| tmo_req_o | output | 1 | Idle timeout request |
| overrun_o | output | 1 | One-cycle pulse for a dropped character |

## Verification
The main function is driven with a table of frames. The table mixes alternating, all-ones, single-bit, high-bit and zero-with-low-stop data, so that bit order, framing-error marking and break marking are each told apart by the flags in the read word. One frame is sent at a slower divider to separate the bit timing from the fixed 14-sample cell. A sub-half-bit glitch separates start qualification from plain edge detection. Filling the queue with an indexed byte sequence, plus one extra character, distinguishes correct ordering and wrap from dropped or overwritten entries. Timeout runs with several codes check for both early and missing requests.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // fill threshold selected by the trigger code
  function automatic logic [6:0] trig_threshold(input logic [2:0] code);
    case (code)
      3'd0:    trig_threshold = 7'd1;
      3'd1:    trig_threshold = 7'd4;
      3'd2:    trig_threshold = 7'd8;
      3'd3:    trig_threshold = 7'd16;
      3'd4:    trig_threshold = 7'd32;
      default: trig_threshold = 7'd48;
    endcase
  endfunction

endpackage

// File: rtl/hsrx_tick.sv
module hsrx_tick #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  logic [RATE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= rate_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: the counter restarts right after every tick
  assert_tick_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/hsrx_deser.sv
module hsrx_deser
  import hsrx_pkg::*;
#(
  parameter int unsigned OSR = 14
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rxd_i,
  output logic      push_o,
  output rx_entry_t entry_o,
  output logic      busy_o
);

  localparam int unsigned SW = $clog2(OSR);
  localparam int unsigned BW = $clog2(DATA_W);
  localparam logic [SW-1:0] MID_S  = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] LAST_S = SW'(OSR - 1);
  localparam logic [BW-1:0] LAST_B = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [SW-1:0]     scnt_q, scnt_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              push_q, push_d;
  rx_entry_t         entry_q, entry_d;

  always_comb begin
    state_d = state_q;
    scnt_d  = scnt_q;
    bcnt_d  = bcnt_q;
    shift_d = shift_q;
    push_d  = 1'b0;
    entry_d = entry_q;
    if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!rxd_i) begin
            state_d = RX_START;
            scnt_d  = '0;
          end
        end
        RX_START: begin
          if (scnt_q == MID_S) begin
            scnt_d  = '0;
            bcnt_d  = '0;
            state_d = rxd_i ? RX_IDLE : RX_DATA;
          end else begin
            scnt_d = scnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (scnt_q == LAST_S) begin
            scnt_d  = '0;
            shift_d = {rxd_i, shift_q[DATA_W-1:1]};
            if (bcnt_q == LAST_B) state_d = RX_STOP;
            else                  bcnt_d  = bcnt_q + 1'b1;
          end else begin
            scnt_d = scnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (scnt_q == LAST_S) begin
            scnt_d        = '0;
            push_d        = 1'b1;
            entry_d.data  = shift_q;
            entry_d.brk   = !rxd_i && (shift_q == '0);
            entry_d.ferr  = !rxd_i && (shift_q != '0);
            state_d       = rxd_i ? RX_IDLE : RX_HOLD;
          end else begin
            scnt_d = scnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rxd_i) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      push_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      bcnt_q  <= bcnt_d;
      shift_q <= shift_d;
      push_q  <= push_d;
      entry_q <= entry_d;
    end
  end

  assign push_o  = push_q;
  assign entry_o = entry_q;
  assign busy_o  = (state_q != RX_IDLE);

  // R1: a frame yields a single-cycle store request
  assert_single_push_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_q |=> !push_q);
  // R5: a break entry never carries the framing flag
  assert_break_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_q && entry_q.brk) |-> (!entry_q.ferr && entry_q.data == '0));
  // R5: while waiting for the line to rise, nothing is stored
  assert_hold_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_HOLD) |=> !push_q);

endmodule

// File: rtl/hsrx_fifo.sv
module hsrx_fifo
  import hsrx_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  rx_entry_t                  entry_i,
  input  logic                       pop_i,
  output rx_entry_t                  head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       ovr_o
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_C   = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovr_q, ovr_d;
  logic             wr_en, rd_en;

  always_comb begin
    wr_en = push_i && (cnt_q != FULL_C);
    rd_en = pop_i && (cnt_q != '0);
    ovr_d = push_i && (cnt_q == FULL_C);
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (wr_en) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
    if (rd_en) rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
    if (wr_en && !rd_en)      cnt_d = cnt_q + 1'b1;
    else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  // storage array: written only with its enable, no reset needed
  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= entry_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign ovr_o   = ovr_q;

  // R7: fill never exceeds the depth
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);
  // R8: a store into a full queue leaves the fill unchanged
  assert_drop_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt_q == FULL_C) |=> (cnt_q == FULL_C && ovr_q));
  // R8: overrun is a single-cycle pulse for a single store
  assert_ovr_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !push_i) |=> !ovr_q);
  // R6: a read of an empty queue has no effect
  assert_empty_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/hsrx_timeout.sv
module hsrx_timeout #(
  parameter int unsigned OSR        = 14,
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       busy_i,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       has_data_i,
  input  logic [1:0] sel_i,
  output logic       req_o
);

  localparam int unsigned CHAR_TICKS = OSR * FRAME_BITS;
  localparam int unsigned TW         = $clog2(CHAR_TICKS);
  localparam int unsigned MAX_CH     = 16;
  localparam int unsigned CW         = $clog2(MAX_CH + 1);
  localparam logic [TW-1:0] LAST_T  = TW'(CHAR_TICKS - 1);
  localparam logic [CW-1:0] MAX_C   = CW'(MAX_CH);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [CW-1:0] ccnt_q, ccnt_d;
  logic [CW-1:0] limit;
  logic          restart;

  always_comb begin
    unique case (sel_i)
      2'd1:    limit = CW'(4);
      2'd2:    limit = CW'(8);
      default: limit = CW'(16);
    endcase
    restart = !has_data_i || busy_i || push_i || pop_i;
    tcnt_d  = tcnt_q;
    ccnt_d  = ccnt_q;
    if (restart) begin
      tcnt_d = '0;
      ccnt_d = '0;
    end else if (tick_i) begin
      if (tcnt_q == LAST_T) begin
        tcnt_d = '0;
        if (ccnt_q != MAX_C) ccnt_d = ccnt_q + 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      ccnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      ccnt_q <= ccnt_d;
    end
  end

  assign req_o = (sel_i != 2'd0) && has_data_i && (ccnt_q >= limit);

  // R10: a read always clears the timeout request
  assert_tmo_read_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !req_o);
  // R10: a fresh character restarts the idle window
  assert_tmo_push_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !req_o);

endmodule

// File: rtl/hsrx_receiver.sv
module hsrx_receiver
  import hsrx_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned OSR        = 14,
  parameter int unsigned RATE_W     = 8,
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [2:0]        trig_sel_i,
  input  logic [1:0]        tmo_sel_i,
  input  logic              rd_i,
  output logic [31:0]       rd_word_o,
  output logic [7:0]        rx_level_o,
  output logic              trig_req_o,
  output logic              tmo_req_o,
  output logic              overrun_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned LVL_W = 8;

  logic             rxd_meta_q, rxd_q;
  logic             tick;
  logic             push, busy;
  rx_entry_t        entry, head;
  logic [CNT_W-1:0] fill;
  logic             has_data;

  // two-stage synchronizer, idle-high after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_meta_q <= 1'b1;
      rxd_q      <= 1'b1;
    end else begin
      rxd_meta_q <= rxd_i;
      rxd_q      <= rxd_meta_q;
    end
  end

  hsrx_tick #(.RATE_W(RATE_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rate_i(rate_i),
    .tick_o(tick)
  );

  hsrx_deser #(.OSR(OSR)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rxd_i  (rxd_q),
    .push_o (push),
    .entry_o(entry),
    .busy_o (busy)
  );

  hsrx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .entry_i(entry),
    .pop_i  (rd_i),
    .head_o (head),
    .count_o(fill),
    .ovr_o  (overrun_o)
  );

  assign has_data = (fill != '0);

  hsrx_timeout #(.OSR(OSR), .FRAME_BITS(FRAME_BITS)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .busy_i    (busy),
    .push_i    (push),
    .pop_i     (rd_i),
    .has_data_i(has_data),
    .sel_i     (tmo_sel_i),
    .req_o     (tmo_req_o)
  );

  always_comb begin
    if (has_data) rd_word_o = {21'd0, head.brk, head.ferr, 1'b0, head.data};
    else          rd_word_o = 32'h0000_0100;
    rx_level_o = LVL_W'(fill);
    trig_req_o = (CNT_W'(trig_threshold(trig_sel_i)) <= fill);
  end

  // R6: the empty flag never comes with flags or data
  assert_empty_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word_o[8] |-> (rd_word_o[7:0] == 8'd0 && rd_word_o[10:9] == 2'd0));
  // R9: the fill trigger is never raised with an empty queue
  assert_trig_needs_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_req_o |-> (rx_level_o != 8'd0));

endmodule

// File: tb/sim_hsrx_receiver.sv
module sim_hsrx_receiver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [7:0]  rate = 8'd0;
  logic [2:0]  trig_sel = 3'd0;
  logic [1:0]  tmo_sel = 2'd0;
  logic        rd = 1'b0;
  logic [31:0] word;
  logic [7:0]  level;
  logic        trig, tmo, ovr;

  int compared = 0;
  int mismatched = 0;
  int ovr_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hsrx_receiver u0 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .rate_i(rate),
    .trig_sel_i(trig_sel), .tmo_sel_i(tmo_sel), .rd_i(rd),
    .rd_word_o(word), .rx_level_o(level), .trig_req_o(trig),
    .tmo_req_o(tmo), .overrun_o(ovr)
  );

  always @(negedge clk) if (ovr) ovr_seen++;

  // {data byte, stop bit level, expected low 11 bits of read word}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {8'hA5, 1'b1, 11'h0A5},
    {8'h3C, 1'b1, 11'h03C},
    {8'hFF, 1'b1, 11'h0FF},
    {8'h01, 1'b1, 11'h001},
    {8'h81, 1'b0, 11'h281},
    {8'h00, 1'b0, 11'h400},
    {8'h80, 1'b1, 11'h080}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 14 * (int'(rate) + 1);
  endfunction

  task automatic idle(input int clks);
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rxd = 1'b0;
    idle(bit_clks());
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      idle(bit_clks());
    end
    rxd = stop;
    idle(bit_clks());
    rxd = 1'b1;
    idle(2 * bit_clks());
  endtask

  task automatic pop();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R11 reset state
    check("R11 word", word, 32'h100);
    check("R11 level", {24'd0, level}, 32'd0);
    check("R11 trig", {31'd0, trig}, 32'd0);
    check("R11 tmo", {31'd0, tmo}, 32'd0);
    check("R11 ovr", {31'd0, ovr}, 32'd0);

    // table walk: R1 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][19:12], VEC[v][11]);
      check("R1 level one", {24'd0, level}, 32'd1);
      check("R1/R4/R5 word", word, {21'd0, VEC[v][10:0]});
      pop();
      check("R6 empty after read", word, 32'h100);
    end

    // R6: read strobe on empty queue has no effect
    pop();
    check("R6 level after empty read", {24'd0, level}, 32'd0);
    send_frame(8'h11, 1'b1);
    check("R6 level after empty read+frame", {24'd0, level}, 32'd1);
    check("R6 word after empty read+frame", word, 32'h011);
    pop();

    // R3: short low glitch is rejected
    rxd = 1'b0; idle(3); rxd = 1'b1;
    idle(3 * bit_clks());
    check("R3 glitch no entry", {24'd0, level}, 32'd0);

    // R5: long break gives one entry only
    rxd = 1'b0;
    idle(30 * bit_clks());
    rxd = 1'b1;
    idle(3 * bit_clks());
    check("R5 long break single entry", {24'd0, level}, 32'd1);
    check("R5 long break word", word, 32'h400);
    pop();

    // R2: slower divider
    rate = 8'd2;
    idle(4);
    send_frame(8'h5A, 1'b1);
    check("R2 rate 2 word", word, 32'h05A);
    pop();
    rate = 8'd0;
    idle(4);

    // R9 trigger threshold 4
    trig_sel = 3'd1;
    for (int i = 0; i < 3; i++) send_frame(8'(i), 1'b1);
    check("R9 below 4", {31'd0, trig}, 32'd0);
    send_frame(8'd3, 1'b1);
    check("R9 at 4", {31'd0, trig}, 32'd1);
    trig_sel = 3'd4;
    idle(1);
    check("R9 code4 below 32", {31'd0, trig}, 32'd0);

    // R7/R8 fill to 64 then one more
    for (int i = 4; i < 64; i++) send_frame(8'(i), 1'b1);
    check("R7 full level", {24'd0, level}, 32'd64);
    trig_sel = 3'd7;
    idle(1);
    check("R9 code7 at 64", {31'd0, trig}, 32'd1);
    check("R8 no overrun yet", ovr_seen, 0);
    send_frame(8'hEE, 1'b1);
    check("R8 overrun pulse count", ovr_seen, 1);
    check("R8 level stays 64", {24'd0, level}, 32'd64);
    for (int i = 0; i < 64; i++) begin
      check("R7 order", word, {24'd0, 8'(i)});
      pop();
    end
    check("R8 dropped not stored", word, 32'h100);
    trig_sel = 3'd0;

    // R10 timeout, code 1 = 4 chars = 560 clocks at rate 0
    tmo_sel = 2'd1;
    send_frame(8'h42, 1'b1);
    idle(280);
    check("R10 code1 early", {31'd0, tmo}, 32'd0);
    idle(600);
    check("R10 code1 fired", {31'd0, tmo}, 32'd1);
    pop();
    check("R10 cleared by read", {31'd0, tmo}, 32'd0);

    tmo_sel = 2'd0;
    send_frame(8'h43, 1'b1);
    idle(3000);
    check("R10 disabled", {31'd0, tmo}, 32'd0);
    pop();

    tmo_sel = 2'd3;
    send_frame(8'h44, 1'b1);
    idle(1500);
    check("R10 code3 early", {31'd0, tmo}, 32'd0);
    idle(1000);
    check("R10 code3 fired", {31'd0, tmo}, 32'd1);
    pop();
    check("R10 code3 cleared", {31'd0, tmo}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule